// File: doc/BRIEF.md
# Pseudo-static RAM access controller

This controller connects a synchronous host request port to an external pseudo-static RAM. The memory has three active-low control pins: a chip select, a dual-purpose strobe, and a write enable. The strobe is an output enable while the chip is selected. While the chip is deselected, a low level on the same strobe asks the memory to refresh. The controller runs the start-up sequence and turns each accepted host request into one timed chip-select pulse. Between accesses it issues periodic refresh pulses, and it can park the memory in self refresh.

Every pulse width and guard time is a parameter counted in clock cycles. The host sees a valid/ready handshake and gets read data back with a one-cycle strobe. Ready stays low during start-up, while a refresh is pending or running, and while self refresh is requested. Self refresh begins when `sleep_i` is raised. It ends when `sleep_i` falls, and a recovery window follows in which all control pins stay high.

Top module: `psram_ctrl`

## Requirements
- R1: After reset is released, the chip select, strobe and write enable stay high, with ready low, for at least PWRUP_CYC clock cycles.
- R2: Before ready first rises, at least DUMMY_CNT chip-select pulses are issued. During these pulses the strobe and the write enable stay high.
- R3: The pin encodings are as follows. A read is select low, strobe low, write enable high. A write is select low, write enable low, strobe high. A refresh is select high, strobe low. Standby is all high. The write enable is never low while the select is high.
- R4: Every low pulse on the chip select lasts at least CE_MIN cycles.
- R5: Every refresh low pulse on the strobe (select high) lasts at least RFSH_MIN cycles.
- R6: After the select rises, at least HOLD_CYC cycles pass before the strobe falls for a refresh. After a refresh ends, at least HOLD_CYC cycles pass before the select falls.
- R7: Each accepted read produces exactly one rd_valid_o pulse, one cycle long, in the cycle after its select pulse ends. rd_data_o holds the value last written to that address.
- R8: While sleep_i is low, refresh pulses follow each other with a gap of at most RFSH_INTERVAL+CE_MIN+HOLD_CYC+4 cycles. A pending refresh waits for the current access to finish. Ready is high only in standby.
- R9: While sleep_i is high, the select is held high and the strobe low (self refresh), with ready low.
- R10: After the self-refresh strobe rises, select and strobe both stay high for at least RFS_CYC cycles before either falls.
- R11: dq_oe_o is high only while a write is on the pins (select low, write enable low, strobe high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_addr_i | input | ADDR_W | Request address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| rd_valid_o | output | 1 | One-cycle read data strobe |
| rd_data_o | output | DATA_W | Read data |
| sleep_i | input | 1 | Self-refresh request (level) |
| chip_en_no | output | 1 | Memory chip select, active low |
| out_ref_no | output | 1 | Output enable when selected, refresh strobe when deselected, active low |
| wr_en_no | output | 1 | Memory write enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| dq_o | output | DATA_W | Data toward memory |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | DATA_W | Data from memory |

## Verification
The checker watches the following on every clock:
- the write-enable and bus-direction encodings;
- the minimum select width and the minimum refresh strobe width;
- ready appearing only in standby;
- the shape of the read-data strobe.

The bench's scenarios are the only place where the start-up wait, the dummy-pulse count, the guard gaps on both sides of a refresh, the refresh spacing and the recovery window after self refresh are measured. The same holds for data integrity across mixed traffic and across a sleep period.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_PWRUP, ST_DUMMY_LO, ST_DUMMY_HI, ST_IDLE, ST_ACCESS,
    ST_PRECH, ST_REFRESH, ST_RGUARD, ST_SELF, ST_EXIT
  } psr_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_rfsh_timer.sv
module psram_rfsh_timer #(
  parameter int INTERVAL = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic done_i,
  output logic pend_o
);
  localparam int CW = $clog2(INTERVAL);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      pend_o <= 1'b0;
    end else if (hold_i || done_i) begin
      cnt    <= '0;
      pend_o <= 1'b0;
    end else if (!pend_o) begin
      if (cnt == LAST) begin
        cnt    <= '0;
        pend_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int PWRUP_CYC     = 50,
  parameter int DUMMY_CNT     = 8,
  parameter int CE_MIN        = 3,
  parameter int HOLD_CYC      = 2,
  parameter int RFSH_MIN      = 2,
  parameter int RFS_CYC       = 5,
  parameter int SELF_ENTRY    = 6,
  parameter int RFSH_INTERVAL = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              sleep_i,
  output logic              chip_en_no,
  output logic              out_ref_no,
  output logic              wr_en_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int CNT_MAX = max_int(max_int(PWRUP_CYC, CE_MIN),
                                   max_int(max_int(HOLD_CYC, RFSH_MIN), max_int(RFS_CYC, SELF_ENTRY)));
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int DUM_W = $clog2(DUMMY_CNT + 1);
  localparam logic [CNT_W-1:0] PWR_LAST  = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] CE_LAST   = CNT_W'(CE_MIN - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RF_LAST   = CNT_W'(RFSH_MIN - 1);
  localparam logic [CNT_W-1:0] RFS_LAST  = CNT_W'(RFS_CYC - 1);
  localparam logic [CNT_W-1:0] SELF_SAT  = CNT_W'(SELF_ENTRY);
  localparam logic [DUM_W-1:0] DUM_LAST  = DUM_W'(DUMMY_CNT - 1);

  psr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [DUM_W-1:0] dcnt;
  logic             acc_rd;
  logic             rfsh_pend;
  logic             rfsh_done;
  logic             rfsh_hold;

  assign rfsh_done   = (st == ST_REFRESH) && (cnt == RF_LAST);
  assign rfsh_hold   = (st == ST_SELF) || (st == ST_EXIT);
  assign req_ready_o = (st == ST_IDLE) && !rfsh_pend && !sleep_i;

  psram_rfsh_timer #(.INTERVAL(RFSH_INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (rfsh_hold),
    .done_i (rfsh_done),
    .pend_o (rfsh_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_PWRUP;
      cnt        <= '0;
      dcnt       <= '0;
      acc_rd     <= 1'b0;
      chip_en_no <= 1'b1;
      out_ref_no <= 1'b1;
      wr_en_no   <= 1'b1;
      dq_oe_o    <= 1'b0;
      dq_o       <= '0;
      mem_addr_o <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      cnt        <= cnt + 1'b1;
      unique case (st)
        ST_PWRUP: if (cnt == PWR_LAST) begin
          st <= ST_DUMMY_LO; cnt <= '0; chip_en_no <= 1'b0;
        end
        ST_DUMMY_LO: if (cnt == CE_LAST) begin
          st <= ST_DUMMY_HI; cnt <= '0; chip_en_no <= 1'b1;
        end
        ST_DUMMY_HI: if (cnt == HOLD_LAST) begin
          cnt <= '0;
          if (dcnt == DUM_LAST) st <= ST_IDLE;
          else begin
            dcnt <= dcnt + 1'b1; st <= ST_DUMMY_LO; chip_en_no <= 1'b0;
          end
        end
        ST_IDLE: begin
          cnt <= '0;
          // refresh beats sleep, sleep beats host traffic
          if (rfsh_pend) begin
            st <= ST_REFRESH; out_ref_no <= 1'b0;
          end else if (sleep_i) begin
            st <= ST_SELF; out_ref_no <= 1'b0;
          end else if (req_valid_i) begin
            st         <= ST_ACCESS;
            chip_en_no <= 1'b0;
            wr_en_no   <= ~req_we_i;
            out_ref_no <= req_we_i;
            dq_oe_o    <= req_we_i;
            dq_o       <= req_wdata_i;
            mem_addr_o <= req_addr_i;
            acc_rd     <= ~req_we_i;
          end
        end
        ST_ACCESS: if (cnt == CE_LAST) begin
          st <= ST_PRECH; cnt <= '0;
          chip_en_no <= 1'b1; wr_en_no <= 1'b1; out_ref_no <= 1'b1; dq_oe_o <= 1'b0;
          if (acc_rd) begin
            rd_valid_o <= 1'b1; rd_data_o <= dq_i;
          end
        end
        ST_PRECH, ST_RGUARD: if (cnt == HOLD_LAST) begin
          st <= ST_IDLE; cnt <= '0;
        end
        ST_REFRESH: if (cnt == RF_LAST) begin
          st <= ST_RGUARD; cnt <= '0; out_ref_no <= 1'b1;
        end
        ST_SELF: begin
          if (cnt == SELF_SAT) cnt <= cnt;
          if (!sleep_i && cnt == SELF_SAT) begin
            st <= ST_EXIT; cnt <= '0; out_ref_no <= 1'b1;
          end
        end
        ST_EXIT: if (cnt == RFS_LAST) begin
          st <= ST_IDLE; cnt <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int CE_MIN   = 3,
  parameter int RFSH_MIN = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic chip_en_no,
  input logic out_ref_no,
  input logic wr_en_no,
  input logic dq_oe_o,
  input logic req_ready_o,
  input logic rd_valid_o
);
  int unsigned ce_lo;
  int unsigned rf_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_lo <= 0;
      rf_lo <= 0;
    end else begin
      ce_lo <= chip_en_no ? 0 : ce_lo + 1;
      rf_lo <= (chip_en_no && !out_ref_no) ? rf_lo + 1 : 0;
    end
  end

  p_we_needs_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_no |-> !chip_en_no);
  p_bus_dir_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!chip_en_no && !wr_en_no && out_ref_no));
  p_ce_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_en_no) |-> (ce_lo >= CE_MIN));
  p_rfsh_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_ref_no) && $past(chip_en_no)) |-> (rf_lo >= RFSH_MIN));
  p_ready_standby_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (chip_en_no && out_ref_no));
  p_rdv_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  p_rdv_after_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $rose(chip_en_no));
endmodule

bind psram_ctrl psram_ctrl_chk #(.CE_MIN(CE_MIN), .RFSH_MIN(RFSH_MIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_en_no  (chip_en_no),
  .out_ref_no  (out_ref_no),
  .wr_en_no    (wr_en_no),
  .dq_oe_o     (dq_oe_o),
  .req_ready_o (req_ready_o),
  .rd_valid_o  (rd_valid_o)
);

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;
  localparam int CLK_PERIOD    = 10;
  localparam int PWRUP_CYC     = 50;
  localparam int DUMMY_CNT     = 8;
  localparam int CE_MIN        = 3;
  localparam int HOLD_CYC      = 2;
  localparam int RFSH_MIN      = 2;
  localparam int RFS_CYC       = 5;
  localparam int SELF_ENTRY    = 6;
  localparam int RFSH_INTERVAL = 40;
  localparam int GAP_MAX       = RFSH_INTERVAL + CE_MIN + HOLD_CYC + 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, sleep = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rd_valid, chip_en_no, out_ref_no, wr_en_no, dq_oe;
  logic [7:0] rd_data, mem_addr, dq_o, dq_i;

  logic [7:0] mem_model [256];
  logic [7:0] exp_mem [256];
  int exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, pu_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_ctrl #(
    .ADDR_W(8), .DATA_W(8), .PWRUP_CYC(PWRUP_CYC), .DUMMY_CNT(DUMMY_CNT),
    .CE_MIN(CE_MIN), .HOLD_CYC(HOLD_CYC), .RFSH_MIN(RFSH_MIN), .RFS_CYC(RFS_CYC),
    .SELF_ENTRY(SELF_ENTRY), .RFSH_INTERVAL(RFSH_INTERVAL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .sleep_i(sleep),
    .chip_en_no(chip_en_no), .out_ref_no(out_ref_no), .wr_en_no(wr_en_no),
    .mem_addr_o(mem_addr), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i)
  );

  // memory model drives data during a read cycle
  assign dq_i = (!chip_en_no && !out_ref_no && wr_en_no) ? mem_model[mem_addr] : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_ni) pu_cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  // behavioural monitor
  int  ce_run = 0, rf_run = 0, since_ce = 1000, since_rf = 1000, hi_both = 0, dummies = 0;
  bit  post_self = 0, gap_ok = 0, prev_ce = 1, prev_oe = 1, seen_ce = 0, seen_ready = 0;

  always @(negedge clk) if (rst_ni) begin
    bit refr, ce_fall, rf_fall;
    refr    = chip_en_no && !out_ref_no;
    ce_fall = prev_ce && !chip_en_no;
    rf_fall = prev_oe && refr;

    if (!seen_ce) begin
      if (!chip_en_no) begin
        seen_ce = 1;
        chk(pu_cyc >= PWRUP_CYC, "R1 power-up wait", pu_cyc, PWRUP_CYC);
      end else
        chk(out_ref_no && wr_en_no && !req_ready, "R1 pins idle", {out_ref_no, wr_en_no, req_ready}, 6);
    end
    if (!seen_ready) begin
      if (ce_fall) dummies++;
      if (!chip_en_no) chk(out_ref_no && wr_en_no, "R2 dummy pins", {out_ref_no, wr_en_no}, 3);
      if (req_ready) begin
        seen_ready = 1;
        chk(dummies >= DUMMY_CNT, "R2 dummy count", dummies, DUMMY_CNT);
      end
    end

    if (!wr_en_no) chk(!chip_en_no && out_ref_no, "R3 write encoding", {chip_en_no, out_ref_no}, 1);
    if (dq_oe) chk(!chip_en_no && !wr_en_no && out_ref_no, "R11 bus drive", {chip_en_no, wr_en_no, out_ref_no}, 1);
    if (!chip_en_no && !dq_oe) chk(wr_en_no, "R11 no drive on read", wr_en_no, 1);

    if (ce_fall) begin
      chk(since_rf >= HOLD_CYC, "R6 refresh to select", since_rf, HOLD_CYC);
      if (post_self) begin chk(hi_both >= RFS_CYC, "R10 exit guard", hi_both, RFS_CYC); post_self = 0; end
    end
    if (rf_fall) begin
      chk(since_ce >= HOLD_CYC, "R6 select to refresh", since_ce, HOLD_CYC);
      if (post_self) begin chk(hi_both >= RFS_CYC, "R10 exit guard", hi_both, RFS_CYC); post_self = 0; end
      if (gap_ok) chk(since_rf <= GAP_MAX, "R8 refresh gap", since_rf, GAP_MAX);
    end

    if (!chip_en_no) ce_run++;
    else if (ce_run > 0) begin
      chk(ce_run >= CE_MIN, "R4 select width", ce_run, CE_MIN);
      ce_run = 0;
    end

    if (refr) rf_run++;
    else if (rf_run > 0) begin
      chk(rf_run >= RFSH_MIN, "R5 refresh width", rf_run, RFSH_MIN);
      if (rf_run > SELF_ENTRY) begin post_self = 1; hi_both = 0; gap_ok = 0; end
      else gap_ok = !sleep;
      since_rf = 0;
      rf_run = 0;
    end

    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected read strobe", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(rd_data == 8'(e), "R7 read data", rd_data, e);
      end
    end

    if (!chip_en_no && !wr_en_no && dq_oe) mem_model[mem_addr] = dq_o;

    if (!refr) since_rf++;
    if (!chip_en_no) since_ce = 0; else since_ce++;
    if (chip_en_no && out_ref_no) hi_both++;
    if (sleep) gap_ok = 0;
    prev_ce = chip_en_no;
    prev_oe = out_ref_no;
  end

  task automatic host(input bit we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (we) exp_mem[a] = d;
    else exp_q.push_back(int'(exp_mem[a]));
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R7 reads answered", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_model[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(chip_en_no && out_ref_no && wr_en_no && !dq_oe && !req_ready && !rd_valid,
        "R1 reset state", {chip_en_no, out_ref_no, wr_en_no, dq_oe, req_ready}, 28);
    rst_ni = 1'b1;
    while (!req_ready) @(negedge clk);

    // R7 basic write then read
    for (int i = 0; i < 4; i++) host(1'b1, 8'(i), 8'(8'hA0 + i));
    for (int i = 0; i < 4; i++) host(1'b0, 8'(i), 8'h00);
    drain();

    // R8 mixed traffic across several refresh intervals
    for (int i = 0; i < 40; i++) host(i[0], 8'((i * 37) & 255), 8'((i * 13) ^ 8'h5A));
    for (int i = 0; i < 40; i++) host(1'b0, 8'((i * 37) & 255), 8'h00);
    drain();

    // boundary addresses and data
    host(1'b1, 8'h00, 8'hFF);
    host(1'b1, 8'hFF, 8'h00);
    host(1'b0, 8'hFF, 8'h00);
    host(1'b0, 8'h00, 8'h00);
    drain();

    // R8 idle period: refreshes only
    repeat (150) @(negedge clk);

    // R9 self refresh
    sleep = 1'b1;
    repeat (10) @(negedge clk);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!(chip_en_no && !out_ref_no && !req_ready)) bad++;
      end
      chk(bad == 0, "R9 self refresh held", bad, 0);
    end
    @(negedge clk);
    sleep = 1'b0;

    // R10 exit guard then data retained
    host(1'b0, 8'h00, 8'h00);
    host(1'b0, 8'h03, 8'h00);
    host(1'b1, 8'h10, 8'h3C);
    host(1'b0, 8'h10, 8'h00);
    drain();
    repeat (100) @(negedge clk);
    summary();
  end
endmodule